// File: doc/BRIEF.md
# Progressive-to-Interlaced Field Converter

The block sits in a streaming video pipeline. Frames arrive on a valid/ready sample stream, one packet per frame, framed by start-of-packet and end-of-packet flags. Each input frame becomes one output field. A line is either forwarded or discarded according to the parity of its row index. The parity swaps from one frame to the next, so the output alternates between a field of even rows and a field of odd rows. A flag beside the output data tells which of the two fields the current packet carries.

Frame width and height come in on configuration ports. They are captured when the start-of-packet sample is accepted. Discarded lines are consumed at one sample per cycle and never wait on the downstream side, so the output is idle while they pass. Forwarded samples go through a single output register. Malformed packets are repaired. Samples beyond the configured frame size are thrown away until end-of-packet. A packet that ends early closes the open field at once, adding at most one filler sample.

Top module: `p2i_converter`

## Requirements
- R1: A field of parity 0 carries input rows 0, 2, 4, …; a field of parity 1 carries rows 1, 3, 5, …. Every pixel of a carried row is forwarded unchanged, in input order.
- R2: The field parity is 0 for the first frame after reset and inverts after every input frame, including malformed ones. `out_field` equals the parity of the packet being output on every valid output sample.
- R3: `out_sop` is 1 on the first output sample of a field and 0 otherwise. `out_eop` is 1 only on the sample that closes the field. For a complete frame of height H, that sample is the last pixel of the last carried row, which is the carried row r with r+2 ≥ H.
- R4: While a row that is not carried is being received, `in_ready` is 1 whatever `out_ready` is, and no output sample is produced for it. With `out_ready` held at 1, `out_valid` is 0 from the second sample of such a row onward.
- R5: A carried sample accepted while the output register is empty or being emptied appears on `out_data` with `out_valid` = 1 in the very next cycle. `in_ready` for a carried sample is 1 exactly when the output register is empty or `out_ready` is 1.
- R6: While `out_valid` is 1 and `out_ready` is 0, the output data, flags and parity hold their values.
- R7: After the W×H-th sample of a frame, every further sample up to and including the one with `in_eop` = 1 is accepted with `in_ready` = 1 and discarded. The next frame is processed normally.
- R8: If `in_eop` arrives before the W×H-th sample: when that sample is carried, it is output with `out_eop` = 1. When it is not carried and the field has not been closed yet, exactly one filler sample with data 0 and `out_eop` = 1 is output. That filler also has `out_sop` = 1 if no sample of the field has been output yet.
- R9: Samples arriving without `in_sop` = 1 while no frame is in progress are accepted with `in_ready` = 1 and produce no output.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1 while no input is offered.
- R11: `cfg_width` and `cfg_height` are read only when the start-of-packet sample is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | WB | Pixels per line (≥ 1), captured at start of frame |
| cfg_height | input | HB | Lines per frame (≥ 2), captured at start of frame |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with `in_valid` |
| in_data | input | DATA_W | Input pixel |
| in_sop | input | 1 | Input start of packet (first pixel of frame) |
| in_eop | input | 1 | Input end of packet |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can take the output sample |
| out_data | output | DATA_W | Output pixel |
| out_sop | output | 1 | First sample of the output field |
| out_eop | output | 1 | Last sample of the output field |
| out_field | output | 1 | Parity of the field being output (0: even rows, 1: odd rows) |

## Verification
Several properties are checked on every cycle at the output: packet framing (start follows end), a constant parity within a packet, alternating parity between consecutive packets, and stability under backpressure. One internal property also runs every cycle: readiness while a discarded row is being received. Only the bench scenarios show which rows and pixels are actually selected, where end-of-packet falls for each width and height, the one-cycle forwarding delay, and idle output during dropped rows. The same holds for the repair of long and short packets, the filler sample, and the fact that configuration changes in mid-frame are ignored. The bench compares these against values computed arithmetically over a sweep of small frame sizes and every early-termination position.

// File: rtl/p2i_pkg.sv
// Shared types for the progressive-to-interlaced converter.
package p2i_pkg;

    // Frame-level control state.
    //   ST_SEEK  : no frame in progress, waiting for a start-of-packet sample
    //   ST_PASS  : inside a frame, selecting rows by parity
    //   ST_FLUSH : frame size reached, discarding surplus samples until end-of-packet
    //   ST_PAD   : early end-of-packet on a discarded row, emitting one filler sample
    typedef enum logic [1:0] {
        ST_SEEK  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_PAD   = 2'd3
    } p2i_state_e;

endpackage

// File: rtl/p2i_raster_cnt.sv
// Raster position tracker.
// Tracks column and row of the sample on the input port. While seeking, it
// uses the configuration ports directly and captures them when the first
// sample is taken. Reports whether the current row is carried in the given
// field parity, whether the current sample is the last of the frame, and
// whether it is the last pixel of the last carried row.
// Assumes width >= 1 and height >= 2; the counters are cleared at frame end.
module p2i_raster_cnt #(
    parameter int WB = 13,
    parameter int HB = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seeking,
    input  logic          adv,
    input  logic          clr,
    input  logic          field,
    input  logic [WB-1:0] cfg_w,
    input  logic [HB-1:0] cfg_h,
    output logic          keep,
    output logic          last_pix,
    output logic          field_end
);

    logic [WB-1:0] col_q, lat_w, eff_w;
    logic [HB-1:0] row_q, lat_h, eff_h;
    logic [WB:0]   col_nx;
    logic [HB:0]   row_nx, row_n2;
    logic          col_last, row_last, tail_row;

    // Frame geometry in force: live ports before the frame, captured values during it.
    assign eff_w = seeking ? cfg_w : lat_w;
    assign eff_h = seeking ? cfg_h : lat_h;

    // Position arithmetic one bit wider so the comparisons cannot wrap.
    assign col_nx = {1'b0, col_q} + {{WB{1'b0}}, 1'b1};
    assign row_nx = {1'b0, row_q} + {{HB{1'b0}}, 1'b1};
    assign row_n2 = {1'b0, row_q} + {{(HB-1){1'b0}}, 2'b10};

    assign col_last  = (col_nx == {1'b0, eff_w});
    assign row_last  = (row_nx == {1'b0, eff_h});
    assign tail_row  = (row_n2 >= {1'b0, eff_h});

    assign keep      = (row_q[0] == field);
    assign last_pix  = col_last & row_last;
    assign field_end = keep & col_last & tail_row;

    // Capture the geometry when the first sample of a frame is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_w <= '0;
            lat_h <= '0;
        end else if (seeking && adv) begin
            lat_w <= cfg_w;
            lat_h <= cfg_h;
        end
    end

    // Advance the raster position per taken sample; restart at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (clr) begin
            col_q <= '0;
            row_q <= '0;
        end else if (adv) begin
            if (col_last) begin
                col_q <= '0;
                row_q <= row_nx[HB-1:0];
            end else begin
                col_q <= col_nx[WB-1:0];
            end
        end
    end

endmodule

// File: rtl/p2i_frame_ctrl.sv
// Frame controller.
// Decides per input sample whether it is taken as a frame pixel, forwarded or
// dropped. It generates the input ready and the load strobe of the output
// register, repairs long and short packets, and owns the field parity.
// Assumes the output register accepts a load only when slot_free is high.
module p2i_frame_ctrl
    import p2i_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic       in_eop,
    input  logic       keep,
    input  logic       last_pix,
    input  logic       field_end,
    input  logic       slot_free,
    output logic       in_ready,
    output logic       adv,
    output logic       clr,
    output logic       seeking,
    output logic       load,
    output logic       ld_sop,
    output logic       ld_eop,
    output logic       ld_pad,
    output logic       field,
    output p2i_state_e state
);

    p2i_state_e st_q, st_d;
    logic       field_q, started_q, closed_q;
    logic       take, fire, pad_need, pad_go, done;

    // Per-sample decisions and next state.
    always_comb begin
        take     = ((st_q == ST_SEEK) && in_sop) || (st_q == ST_PASS);
        in_ready = 1'b1;
        if (st_q == ST_PAD) begin
            in_ready = 1'b0;
        end else if (take && keep) begin
            in_ready = slot_free;
        end
        fire     = in_valid && in_ready;
        adv      = fire && take;
        pad_need = adv && in_eop && !last_pix && !keep && !closed_q;
        pad_go   = (st_q == ST_PAD) && slot_free;
        load     = (adv && keep) || pad_go;
        ld_pad   = (st_q == ST_PAD);
        ld_sop   = !started_q;
        ld_eop   = ld_pad || field_end || in_eop;
        done     = (adv && (last_pix || in_eop) && !pad_need) || pad_go;

        st_d = st_q;
        case (st_q)
            ST_SEEK, ST_PASS: begin
                if (adv) begin
                    if (last_pix) begin
                        st_d = in_eop ? ST_SEEK : ST_FLUSH;
                    end else if (in_eop) begin
                        st_d = pad_need ? ST_PAD : ST_SEEK;
                    end else begin
                        st_d = ST_PASS;
                    end
                end
            end
            ST_FLUSH: begin
                if (fire && in_eop) begin
                    st_d = ST_SEEK;
                end
            end
            ST_PAD: begin
                if (slot_free) begin
                    st_d = ST_SEEK;
                end
            end
            default: st_d = ST_SEEK;
        endcase
    end

    // State, field parity and open/closed tracking of the current field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_SEEK;
            field_q   <= 1'b0;
            started_q <= 1'b0;
            closed_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (done) begin
                field_q   <= ~field_q;
                started_q <= 1'b0;
                closed_q  <= 1'b0;
            end else if (load) begin
                started_q <= 1'b1;
                if (ld_eop) begin
                    closed_q <= 1'b1;
                end
            end
        end
    end

    assign clr     = done;
    assign seeking = (st_q == ST_SEEK);
    assign field   = field_q;
    assign state   = st_q;

endmodule

// File: rtl/p2i_out_reg.sv
// Output holding register.
// One stage between the selection logic and the downstream port. A load writes
// the sample (or a zero filler) and its flags; the register empties on a
// handshake. Assumes load is raised only while slot_free is high.
module p2i_out_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              ld_sop,
    input  logic              ld_eop,
    input  logic              ld_field,
    input  logic              ld_pad,
    input  logic              out_ready,
    output logic              slot_free,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_field
);

    assign slot_free = !out_valid || out_ready;

    // Hold the current output sample; refill or drain on the handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_field <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= ld_pad ? '0 : ld_data;
            out_sop   <= ld_sop;
            out_eop   <= ld_eop;
            out_field <= ld_field;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/p2i_converter.sv
// Progressive-to-interlaced converter, top level.
// Turns each progressive input frame into one field by carrying rows whose
// parity matches the field and dropping the others. The parity swaps every
// frame. Long packets are trimmed and short ones are closed early.
// Assumes cfg_width >= 1 and cfg_height >= 2, stable while a frame starts.
module p2i_converter
    import p2i_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int MAX_W  = 4096,
    parameter int MAX_H  = 4096,
    localparam int WB    = $clog2(MAX_W + 1),
    localparam int HB    = $clog2(MAX_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WB-1:0]     cfg_width,
    input  logic [HB-1:0]     cfg_height,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_field
);

    logic       keep_w, last_pix_w, field_end_w;
    logic       adv_w, clr_w, seeking_w, field_w;
    logic       load_w, ld_sop_w, ld_eop_w, ld_pad_w, slot_free_w;
    p2i_state_e state_w;

    p2i_raster_cnt #(
        .WB(WB),
        .HB(HB)
    ) raster_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .seeking   (seeking_w),
        .adv       (adv_w),
        .clr       (clr_w),
        .field     (field_w),
        .cfg_w     (cfg_width),
        .cfg_h     (cfg_height),
        .keep      (keep_w),
        .last_pix  (last_pix_w),
        .field_end (field_end_w)
    );

    p2i_frame_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .keep      (keep_w),
        .last_pix  (last_pix_w),
        .field_end (field_end_w),
        .slot_free (slot_free_w),
        .in_ready  (in_ready),
        .adv       (adv_w),
        .clr       (clr_w),
        .seeking   (seeking_w),
        .load      (load_w),
        .ld_sop    (ld_sop_w),
        .ld_eop    (ld_eop_w),
        .ld_pad    (ld_pad_w),
        .field     (field_w),
        .state     (state_w)
    );

    p2i_out_reg #(
        .DATA_W(DATA_W)
    ) oreg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .ld_data   (in_data),
        .ld_sop    (ld_sop_w),
        .ld_eop    (ld_eop_w),
        .ld_field  (field_w),
        .ld_pad    (ld_pad_w),
        .out_ready (out_ready),
        .slot_free (slot_free_w),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_field (out_field)
    );

endmodule

// File: rtl/p2i_checker.sv
// Protocol checker for the converter, attached by bind.
// Watches output framing, parity and backpressure behaviour every cycle,
// plus input readiness while a dropped row is received.
module p2i_checker
    import p2i_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_field,
    input p2i_state_e        cur_state,
    input logic              cur_keep
);

    logic exp_sop_q, pkt_field_q, prev_field_q, have_prev_q;

    // Reference framing state built from output handshakes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_sop_q    <= 1'b1;
            pkt_field_q  <= 1'b0;
            prev_field_q <= 1'b0;
            have_prev_q  <= 1'b0;
        end else if (out_valid && out_ready) begin
            exp_sop_q <= out_eop;
            if (out_sop) begin
                pkt_field_q  <= out_field;
                prev_field_q <= out_field;
                have_prev_q  <= 1'b1;
            end
        end
    end

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
                                       && $stable(out_eop) && $stable(out_field)));

    a_r3_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == exp_sop_q));

    a_r2_field_const_in_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> (out_field == pkt_field_q));

    a_r2_field_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop && have_prev_q) |-> (out_field != prev_field_q));

    a_r4_drop_row_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_state == ST_PASS) && !cur_keep) |-> in_ready);

endmodule

bind p2i_converter p2i_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_field (out_field),
    .cur_state (state_w),
    .cur_keep  (keep_w)
);

// File: tb/p2i_converter_tb_top.sv
// Self-checking bench: sweeps small frame sizes, backpressure patterns,
// long packets and every early end-of-packet position.
module p2i_converter_tb_top;

    localparam int DW = 16;
    localparam int MW = 8;
    localparam int MH = 8;
    localparam int WB = $clog2(MW + 1);
    localparam int HB = $clog2(MH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WB-1:0] cfg_width = '0;
    logic [HB-1:0] cfg_height = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [DW-1:0] out_data;
    logic          out_sop;
    logic          out_eop;
    logic          out_field;

    typedef struct packed {
        logic [DW-1:0] d;
        logic          sop;
        logic          eop;
        logic          fld;
        logic          pad;
    } exp_t;

    exp_t          exp_q[$];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            rdy_mode = 1'b0;
    bit            fld_next = 1'b0;
    int            frame_id = 0;
    bit            pend_lat = 1'b0;
    logic [DW-1:0] pend_d = '0;
    string         cur_tag = "R1";
    logic [7:0]    lfsr = 8'h5a;

    always #5 clk = ~clk;

    p2i_converter #(
        .DATA_W(DW),
        .MAX_W (MW),
        .MAX_H (MH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_width (cfg_width),
        .cfg_height(cfg_height),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_field (out_field)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Downstream ready: always high, or a pseudo-random pattern.
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = rdy_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
        end
    end

    // Output monitor: order, content, flags and stability under stall.
    initial begin
        bit            stalled;
        logic [DW+2:0] held;
        exp_t          e;
        stalled = 1'b0;
        held = '0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) begin
                stalled = 1'b0;
                continue;
            end
            if (stalled) begin
                check(out_valid && ({out_data, out_sop, out_eop, out_field} == held),
                      "R6", "output held under stall", int'(out_data), int'(held[DW+2:3]));
            end
            stalled = out_valid && !out_ready;
            held = {out_data, out_sop, out_eop, out_field};
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1", {"unexpected output sample ", cur_tag}, int'(out_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(out_data == e.d, e.pad ? "R8" : "R1", {"pixel data ", cur_tag},
                          int'(out_data), int'(e.d));
                    check(out_sop == e.sop, "R3", {"start flag ", cur_tag},
                          int'(out_sop), int'(e.sop));
                    check(out_eop == e.eop, "R3", {"end flag ", cur_tag},
                          int'(out_eop), int'(e.eop));
                    check(out_field == e.fld, "R2", {"field parity ", cur_tag},
                          int'(out_field), int'(e.fld));
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    task automatic flush_lat();
        if (pend_lat) begin
            check(out_valid && (out_data == pend_d), "R5", "one-cycle forwarding",
                  int'(out_data), int'(pend_d));
            pend_lat = 1'b0;
        end
    endtask

    task automatic send_sample(input logic [DW-1:0] d, input bit sop, input bit eop,
                               input int cw, input int ch, input string stall_tag,
                               input bit idle_chk, input bit kept_lat);
        int stalls;
        bit r;
        @(negedge clk);
        in_valid   = 1'b1;
        in_data    = d;
        in_sop     = sop;
        in_eop     = eop;
        cfg_width  = WB'(cw);
        cfg_height = HB'(ch);
        #2;
        flush_lat();
        if (idle_chk) check(out_valid == 1'b0, "R4", "output idle on dropped row", int'(out_valid), 0);
        stalls = 0;
        forever begin
            r = in_ready;
            @(posedge clk);
            if (r) break;
            stalls++;
            @(negedge clk);
            #2;
        end
        if (stall_tag != "") check(stalls == 0, stall_tag, "discarded sample taken at once", stalls, 0);
        if (kept_lat) begin
            pend_lat = 1'b1;
            pend_d = d;
        end
    endtask

    task automatic end_stream();
        @(negedge clk);
        in_valid = 1'b0;
        in_sop = 1'b0;
        in_eop = 1'b0;
        #2;
        flush_lat();
    endtask

    // One frame of w x h with len samples, end-of-packet on the last one.
    task automatic send_frame(input int w, input int h, input int len, input bit wobble);
        int   total, lim, cnt, e, lastrow, lastidx, cw, ch, r;
        bit   f, dropped, kept;
        exp_t x;
        string st;
        f = fld_next;
        fld_next = ~fld_next;
        total = w * h;
        lim = (len < total) ? len : total;
        cnt = 0;
        for (int i = 0; i < lim; i++) begin
            if (((i / w) % 2) == int'(f)) begin
                x.d = DW'(frame_id * 64 + i);
                x.sop = (cnt == 0);
                x.eop = 1'b0;
                x.fld = f;
                x.pad = 1'b0;
                exp_q.push_back(x);
                cnt++;
            end
        end
        if (len >= total) begin
            exp_q[exp_q.size() - 1].eop = 1'b1;
        end else begin
            e = len - 1;
            lastrow = (((h - 1) % 2) == int'(f)) ? h - 1 : h - 2;
            lastidx = lastrow * w + w - 1;
            if ((((e / w) % 2) == int'(f)) || (lastidx < e)) begin
                exp_q[exp_q.size() - 1].eop = 1'b1;
            end else begin
                x.d = '0;
                x.sop = (cnt == 0);
                x.eop = 1'b1;
                x.fld = f;
                x.pad = 1'b1;
                exp_q.push_back(x);
            end
        end
        for (int i = 0; i < len; i++) begin
            r = i / w;
            dropped = (i < total) && ((r % 2) != int'(f));
            kept = (i < total) && !dropped;
            cw = (wobble && i > 0) ? w + 2 : w;
            ch = (wobble && i > 0) ? h + 3 : h;
            if (i >= total) st = "R7";
            else if (dropped && i > 0) st = "R4";
            else st = "";
            send_sample(DW'(frame_id * 64 + i), i == 0, i == len - 1, cw, ch, st,
                        dropped && ((i % w) >= 1) && !rdy_mode, kept && !rdy_mode);
        end
        frame_id++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(out_valid == 1'b0, "R10", "no output after reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R10", "ready after reset", int'(in_ready), 1);

        // Junk before any start-of-packet.
        cur_tag = "R9";
        send_sample(16'hdead, 1'b0, 1'b0, 2, 2, "R9", 1'b0, 1'b0);
        send_sample(16'hbeef, 1'b0, 1'b1, 2, 2, "R9", 1'b0, 1'b0);

        // Always-ready sweep: selection, latency, idle output.
        cur_tag = "R1 ready";
        rdy_mode = 1'b0;
        for (int w = 1; w <= 3; w++)
            for (int h = 2; h <= 5; h++)
                send_frame(w, h, w * h, 1'b0);

        cur_tag = "R9 between frames";
        send_sample(16'h0bad, 1'b0, 1'b0, 3, 3, "R9", 1'b0, 1'b0);

        // Backpressure sweep.
        cur_tag = "R6 stalls";
        rdy_mode = 1'b1;
        for (int w = 1; w <= 3; w++)
            for (int h = 2; h <= 5; h++)
                send_frame(w, h, w * h, 1'b0);

        // Long packets.
        cur_tag = "R7 long packet";
        send_frame(3, 3, 12, 1'b0);
        send_frame(2, 4, 10, 1'b0);
        rdy_mode = 1'b0;
        send_frame(2, 3, 9, 1'b0);
        send_frame(3, 2, 7, 1'b0);
        rdy_mode = 1'b1;

        // Short packets at every position.
        cur_tag = "R8 short packet";
        for (int w = 1; w <= 3; w++)
            for (int h = 2; h <= 4; h++)
                for (int n = 1; n < w * h; n++)
                    send_frame(w, h, n, 1'b0);

        // Geometry changes after start-of-packet are ignored.
        cur_tag = "R11 config captured";
        send_frame(3, 4, 12, 1'b1);
        send_frame(2, 5, 10, 1'b1);
        rdy_mode = 1'b0;
        send_frame(3, 3, 9, 1'b1);
        end_stream();

        for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R1", "all expected samples delivered", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule